// File: doc/BRIEF.md
# LNB Supply Control Register

This block holds the control word of a satellite low-noise-block power supply and turns it into the control signals for the supply's power stage and its 22 kHz signalling tone. A host writes six control bits through a simple write port. The same byte can be read back at any time. The two upper bits of the readback are not stored: they show the live overload and overtemperature flags that the protection circuits drive.

One external pin has two meanings, chosen by a mode bit. In tone-signalling mode the pin gates the internal tone, and a register bit selects the output level: either 13 V or the 19.5 V setting. In voltage-signalling mode the pin selects 13 V or 18 V directly, and the tone stays off. A cable-drop bit raises the selected level by about one volt. An undervoltage input forces the outputs into standby without changing the stored word. The tone is produced by dividing the system clock, and the division ratio comes from a clock-frequency parameter.

Top module: `lnb_ctrl_reg`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[5:0]` at the next clock edge, and `rd_data[5:0]` returns the stored bits in the same positions: bit 0 enable, bit 1 high-level select, bit 2 cable-drop boost, bit 3 transmit keep, bit 4 pulsed-limit select, bit 5 mode (0 tone-signalling, 1 voltage-signalling). Without `wr_en` the stored bits do not change.
- R2: `rd_data[6]` shows `ovl_flag` and `rd_data[7]` shows `ovt_flag` in the same cycle. Writes to bits 7:6 have no effect.
- R3: A clock edge with `rst` high clears all six control bits. After that edge every output is in standby: `pwr_en`=0, `lvl_code`=00, `drop_comp`=0, `tone_en`=0, `tone_out`=0.
- R4: While the enable bit is 0, `pwr_en`, `drop_comp` and `tone_en` are 0 and `lvl_code` is 00, whatever the other bits and the pin are.
- R5: While `uvlo` is 1, the outputs are in the same standby state as in R4, and the stored control bits are kept unchanged on readback.
- R6: When enabled in mode 0, `lvl_code` is 10 (19.5 V) if the high-level select bit is 1 and 00 (13 V) otherwise. `sel_pin` does not affect the level.
- R7: When enabled in mode 1, `lvl_code` is 01 (18 V) if `sel_pin` is 1 and 00 (13 V) otherwise. The high-level select bit is ignored and `tone_en` is 0.
- R8: When enabled, `drop_comp` equals the cable-drop boost bit.
- R9: `tone_en` is 1 only when the block is enabled, the mode bit is 0, the transmit keep bit is 1 and `sel_pin` is 1.
- R10: With `tone_en` high, `tone_out` toggles every CLK_HZ/44000 clock cycles. Its first rise comes that many edges after `tone_en` goes high. It becomes 0 at the first edge at which `tone_en` is low.
- R11: `lvl_code` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to store (bits 7:6 ignored) |
| rd_data | output | 8 | Stored control bits with live diagnostic flags |
| sel_pin | input | 1 | Dual-function pin: tone gate or level select |
| uvlo | input | 1 | Undervoltage lockout, forces standby |
| ovl_flag | input | 1 | Overload status from the current limiter |
| ovt_flag | input | 1 | Overtemperature status from the thermal sensor |
| pwr_en | output | 1 | Power stage enable |
| lvl_code | output | 2 | Output level: 00 13 V, 01 18 V, 10 19.5 V |
| drop_comp | output | 1 | Cable-drop boost enable |
| tone_en | output | 1 | Tone path enable |
| tone_out | output | 1 | 22 kHz tone waveform |

## Verification
The bench changes the dual-function pin across both modes. A design that read the pin in the wrong mode would show the level following the pin in tone-signalling mode, or the tone being gated in voltage-signalling mode. Undervoltage is applied while a full control word is stored, and the readback is checked afterwards: a design that cleared the register instead of masking the outputs would lose the stored word. Writing all ones checks that the top two readback bits still follow only the flags. The tone is timed edge by edge through its first rise and its first fall, and it is stopped while high, so an off-by-one divider or a tone that finishes its phase before stopping is reported.

// File: rtl/lnb_ctrl_pkg.sv
package lnb_ctrl_pkg;

    localparam int CTRL_W = 6;

    typedef struct packed {
        logic volt_mode;   // bit 5
        logic pulse_lim;   // bit 4
        logic tx_keep;     // bit 3
        logic boost;       // bit 2
        logic hi_sel;      // bit 1
        logic on;          // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        LVL_13V  = 2'b00,
        LVL_18V  = 2'b01,
        LVL_19V5 = 2'b10
    } lvl_t;

    function automatic int unsigned half_period(input int unsigned clk_hz,
                                                input int unsigned tone_hz);
        return clk_hz / (2 * tone_hz);
    endfunction

endpackage

// File: rtl/lnb_cfg_store.sv
module lnb_cfg_store
    import lnb_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        ovl_flag,
    input  logic        ovt_flag,
    output ctrl_t       ctrl,
    output logic [7:0]  rd_data
);

    logic unused_hi;
    assign unused_hi = ^wr_data[7:6];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign rd_data = {ovt_flag, ovl_flag, ctrl};

    assert_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[5:0] == $past(wr_data[5:0])));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl));

    assert_clear_R3: assert property (@(posedge clk)
        rst |=> (ctrl == '0));

endmodule

// File: rtl/lnb_level_decode.sv
module lnb_level_decode
    import lnb_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  sel_pin,
    input  logic  uvlo,
    output logic  pwr_en,
    output lvl_t  lvl_code,
    output logic  drop_comp,
    output logic  tone_en
);

    logic active;

    always_comb begin
        active    = ctrl.on && !uvlo;
        pwr_en    = active;
        drop_comp = active && ctrl.boost;
        tone_en   = active && !ctrl.volt_mode && ctrl.tx_keep && sel_pin;
        lvl_code  = LVL_13V;
        if (active) begin
            if (ctrl.volt_mode) begin
                lvl_code = sel_pin ? LVL_18V : LVL_13V;
            end else begin
                lvl_code = ctrl.hi_sel ? LVL_19V5 : LVL_13V;
            end
        end
    end

    assert_standby_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.on |-> (!pwr_en && !drop_comp && !tone_en && lvl_code == LVL_13V));

    assert_uvlo_R5: assert property (@(posedge clk) disable iff (rst)
        uvlo |-> (!pwr_en && !drop_comp && !tone_en && lvl_code == LVL_13V));

    assert_no_tone_vmode_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.volt_mode |-> !tone_en);

    assert_legal_level_R11: assert property (@(posedge clk) disable iff (rst)
        lvl_code != 2'b11);

endmodule

// File: rtl/lnb_tone_gen.sv
module lnb_tone_gen #(
    parameter int unsigned HALF = 2840
) (
    input  logic clk,
    input  logic rst,
    input  logic tone_en,
    output logic tone_out
);

    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !tone_en) begin
            cnt      <= '0;
            tone_out <= 1'b0;
        end else if (wrap) begin
            cnt      <= '0;
            tone_out <= ~tone_out;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    assert_tone_off_R10: assert property (@(posedge clk) disable iff (rst)
        !tone_en |=> !tone_out);

    assert_tone_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tone_en && !wrap) |=> (tone_out == $past(tone_out)));

    assert_tone_flip_R10: assert property (@(posedge clk) disable iff (rst)
        (tone_en && wrap) |=> (tone_out != $past(tone_out)));

endmodule

// File: rtl/lnb_ctrl_reg.sv
module lnb_ctrl_reg
    import lnb_ctrl_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned TONE_HZ = 22_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sel_pin,
    input  logic       uvlo,
    input  logic       ovl_flag,
    input  logic       ovt_flag,
    output logic       pwr_en,
    output logic [1:0] lvl_code,
    output logic       drop_comp,
    output logic       tone_en,
    output logic       tone_out
);

    localparam int unsigned HALF = half_period(CLK_HZ, TONE_HZ);

    ctrl_t ctrl;
    lvl_t  lvl;

    lnb_cfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ovl_flag (ovl_flag),
        .ovt_flag (ovt_flag),
        .ctrl     (ctrl),
        .rd_data  (rd_data)
    );

    lnb_level_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .sel_pin   (sel_pin),
        .uvlo      (uvlo),
        .pwr_en    (pwr_en),
        .lvl_code  (lvl),
        .drop_comp (drop_comp),
        .tone_en   (tone_en)
    );

    assign lvl_code = lvl;

    lnb_tone_gen #(.HALF(HALF)) u_tone (
        .clk      (clk),
        .rst      (rst),
        .tone_en  (tone_en),
        .tone_out (tone_out)
    );

    initial begin
        assert_half_R10: assert (HALF >= 2)
            else $error("tone half period too short");
    end

endmodule

// File: tb/lnb_ctrl_reg_tb.sv
module lnb_ctrl_reg_tb;

    localparam int unsigned CLK_HZ = 440_000;
    localparam int          HALF   = 10;
    localparam int          NV     = 13;

    // {ctrl[5:0], pin, uvlo, exp_pwr, exp_lvl[1:0], exp_drop, exp_tone}
    localparam logic [12:0] VEC [NV] = '{
        {6'b000000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
        {6'b111110, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
        {6'b000001, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
        {6'b000011, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
        {6'b000011, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
        {6'b001011, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1},
        {6'b001001, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
        {6'b000101, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0},
        {6'b100001, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0},
        {6'b100011, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
        {6'b101111, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0},
        {6'b101111, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0},
        {6'b001111, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sel_pin = 1'b0;
    logic       uvlo = 1'b0;
    logic       ovl_flag = 1'b0;
    logic       ovt_flag = 1'b0;
    logic       pwr_en;
    logic [1:0] lvl_code;
    logic       drop_comp;
    logic       tone_en;
    logic       tone_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lnb_ctrl_reg #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sel_pin(sel_pin), .uvlo(uvlo),
        .ovl_flag(ovl_flag), .ovt_flag(ovt_flag), .pwr_en(pwr_en),
        .lvl_code(lvl_code), .drop_comp(drop_comp), .tone_en(tone_en),
        .tone_out(tone_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst = 1'b0;
        // R3 reset state
        chk("R3 rd", {8'h0, rd_data}, 16'h0000);
        chk("R3 outs", {11'h0, pwr_en, lvl_code, drop_comp, tone_en}, 16'h0);
        chk("R3 tone_out", {15'h0, tone_out}, 16'h0);

        // vector table: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            wr({2'b00, VEC[v][12:7]});
            sel_pin = VEC[v][6];
            uvlo    = VEC[v][5];
            #1;
            chk($sformatf("R4-9 vec%0d", v),
                {11'h0, pwr_en, lvl_code, drop_comp, tone_en},
                {11'h0, VEC[v][4:0]});
        end
        uvlo = 1'b0;
        sel_pin = 1'b0;

        // R1 readback and R2 ignored upper bits
        wr(8'hFF);
        chk("R1 R2 rd all ones", {8'h0, rd_data}, 16'h003F);
        wr(8'h95);
        chk("R1 rd pattern", {8'h0, rd_data}, 16'h0015);
        @(negedge clk);
        chk("R1 hold", {8'h0, rd_data}, 16'h0015);
        ovl_flag = 1'b1;
        #1;
        chk("R2 ovl bit6", {8'h0, rd_data}, 16'h0055);
        ovt_flag = 1'b1;
        ovl_flag = 1'b0;
        #1;
        chk("R2 ovt bit7", {8'h0, rd_data}, 16'h0095);
        ovt_flag = 1'b0;

        // R5 register kept under undervoltage
        wr(8'h2F);
        uvlo = 1'b1;
        edges(3);
        chk("R5 rd kept", {8'h0, rd_data}, 16'h002F);
        chk("R5 pwr off", {15'h0, pwr_en}, 16'h0);
        uvlo = 1'b0;
        #1;
        chk("R5 resume", {14'h0, lvl_code}, 16'h0000);

        // R10 tone timing: enable, transmit keep, mode 0
        wr(8'h09);
        chk("R10 idle low", {15'h0, tone_out}, 16'h0);
        sel_pin = 1'b1;
        edges(HALF - 1);
        chk("R10 before first rise", {15'h0, tone_out}, 16'h0);
        edges(1);
        chk("R10 first rise", {15'h0, tone_out}, 16'h1);
        edges(HALF - 1);
        chk("R10 high hold", {15'h0, tone_out}, 16'h1);
        edges(1);
        chk("R10 first fall", {15'h0, tone_out}, 16'h0);
        edges(HALF + 5);
        chk("R10 mid high", {15'h0, tone_out}, 16'h1);
        sel_pin = 1'b0;
        edges(1);
        chk("R10 stop low", {15'h0, tone_out}, 16'h0);
        chk("R9 pin off", {15'h0, tone_en}, 16'h0);

        // R3 reset during operation
        wr(8'h0F);
        sel_pin = 1'b1;
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        chk("R3 mid reset rd", {8'h0, rd_data}, 16'h0000);
        chk("R3 mid reset outs", {11'h0, pwr_en, lvl_code, drop_comp, tone_en}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule